// File: doc/BRIEF.md
# NMI Source Latch and System Control Port

This block holds the board-level logic that raises the non-maskable interrupt. It watches two error sources: a parity error input that is active high, and an I/O channel check input that is active low. When a source is enabled and its input is asserted, the block latches a status flag for that source. The flag stays set after the input goes away. Software clears a flag by writing 1 to that source's disable bit. The same write also stops the source from latching again until software writes 0 to the bit.

The combined request is the OR of the two status flags. It is blocked while a global mask bit is set. The mask bit sits in a second port, whose lower seven bits are passed unchanged to a neighbouring real-time clock block as an index. Each rising edge of the unmasked request produces a one-cycle NMI pulse.

The control port also carries four unrelated bits:
- a refresh indicator that toggles on every refresh tick;
- a live view of the interval timer's counter 2 output;
- a speaker data bit;
- the counter 2 gate.

The speaker data bit and the counter 2 gate are read/write and drive output pins.

Top module: `nmi_ctrl_port`

## Requirements
- R1: After reset, the control port reads `{0,0,cnt2,0,1,1,0,0}`: both sources disabled, speaker and gate 0. The mask port reads 80h, `nmi_o` is 0 and `rtc_index_o` is 0.
- R2: While control bit 2 is 0, a high `par_err_i` at a clock edge sets control bit 7 from that edge on. Bit 7 stays set after `par_err_i` falls.
- R3: While control bit 3 is 0, a low `iochk_n_i` at a clock edge sets control bit 6 from that edge on. Bit 6 stays set after the input returns high.
- R4: A control write with bit 2 = 1 clears bit 7 and stores 1 in bit 2. While bit 2 reads 1, `par_err_i` has no effect on bit 7. Writing bit 2 = 0 re-enables the source.
- R5: A control write with bit 3 = 1 clears bit 6 and stores 1 in bit 3. While bit 3 reads 1, `iochk_n_i` has no effect on bit 6.
- R6: Write data in control bits 7, 6, 5 and 4 is ignored.
- R7: Control bit 4 inverts at each clock edge where `refresh_tick_i` is high.
- R8: Control bit 5 shows `cnt2_out_i` in the same cycle.
- R9: Control bits 1 (speaker data) and 0 (counter 2 gate) are written by control-port writes, read back, and drive `spkr_data_o` and `cnt2_gate_o`.
- R10: A mask-port write stores data bit 7 as the global mask and bits 6:0 as the index. The mask port reads back `{mask,index}` and `rtc_index_o` shows the index.
- R11: The request is (bit 7 OR bit 6) AND NOT mask. `nmi_o` is high for exactly the one cycle that follows the cycle in which the request rose. It does not pulse again while the request stays high.
- R12: While the mask is set, `nmi_o` stays low. Clearing the mask while a status bit is set gives one pulse.
- R13: A read at any other address returns 00h. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address for read and write |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` (combinational) |
| par_err_i | input | 1 | Parity error, active high |
| iochk_n_i | input | 1 | I/O channel check, active low |
| refresh_tick_i | input | 1 | One-cycle refresh event |
| cnt2_out_i | input | 1 | Interval timer counter 2 output |
| nmi_o | output | 1 | NMI pulse to the processor |
| cnt2_gate_o | output | 1 | Counter 2 gate |
| spkr_data_o | output | 1 | Speaker data |
| rtc_index_o | output | 7 | Index bits for the RTC block |

## Verification
Short single-cycle error pulses check that a source latches and that the flag survives the input going away. An error held high across a disable write checks that the clear takes priority over a set in the same cycle. Pending status is held behind the mask and then unmasked, which separates an edge-based NMI pulse from a level output. A random mix of writes, error inputs and ticks, compared cycle by cycle against a model, checks the priority between clear, set and hold across many combinations.

// File: rtl/nmi_ctrl_pkg.sv
package nmi_ctrl_pkg;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = 7;
    localparam int NSRC    = 2;
    // Source 0: parity error, source 1: I/O check.
    // Disable bit of source s is 2+s, its status bit is 7-s.
    localparam int DIS_LSB = 2;
    localparam int STAT_MSB = 7;

    typedef struct packed {
        logic             mask;
        logic [IDX_W-1:0] idx;
        logic             refr;
        logic             spk;
        logic             gate;
    } port_state_t;
endpackage

// File: rtl/nmi_src_latch.sv
module nmi_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic err_i,
    input  logic ctl_wr_i,
    input  logic dis_bit_i,
    output logic dis_o,
    output logic stat_o
);
    typedef struct packed {
        logic stat;
        logic dis;
    } src_t;

    src_t src_d, src_q;

    always_comb begin
        src_d = src_q;
        if (ctl_wr_i) begin
            src_d.dis = dis_bit_i;
        end
        if (ctl_wr_i && dis_bit_i) begin
            src_d.stat = 1'b0;
        end else if (!src_q.dis && err_i) begin
            src_d.stat = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '{stat: 1'b0, dis: 1'b1};
        end else begin
            src_q <= src_d;
        end
    end

    assign dis_o  = src_q.dis;
    assign stat_o = src_q.stat;

    // R2 / R3: an enabled source latches its error
    assert_latch_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis_o && err_i && !(ctl_wr_i && dis_bit_i)) |=> stat_o);
    // R4 / R5: writing the disable bit clears the status
    assert_clear_on_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && dis_bit_i) |=> (!stat_o && dis_o));
    // R3: the status holds until it is cleared
    assert_status_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && !(ctl_wr_i && dis_bit_i)) |=> stat_o);
    // R5: a disabled source never sets its status
    assert_disabled_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_o && !stat_o) |=> !stat_o);
endmodule

// File: rtl/nmi_pulse.sv
module nmi_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } pls_t;

    pls_t pls_d, pls_q;

    always_comb begin
        pls_d.prev  = req_i;
        pls_d.pulse = req_i && !pls_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pls_q <= '0;
        end else begin
            pls_q <= pls_d;
        end
    end

    assign pulse_o = pls_q.pulse;

    // R11: the pulse lasts exactly one cycle
    assert_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    // R11: a pulse follows a cycle with the request active
    assert_pulse_has_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(req_i));
endmodule

// File: rtl/nmi_ctrl_port.sv
module nmi_ctrl_port
    import nmi_ctrl_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTL_ADDR  = 16'h0061,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h0070
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              par_err_i,
    input  logic              iochk_n_i,
    input  logic              refresh_tick_i,
    input  logic              cnt2_out_i,
    output logic              nmi_o,
    output logic              cnt2_gate_o,
    output logic              spkr_data_o,
    output logic [6:0]        rtc_index_o
);
    logic ctl_wr, mask_wr;
    logic [NSRC-1:0] err_vec, dis_vec, stat_vec;
    logic gated_req;
    port_state_t st_d, st_q;

    assign ctl_wr  = io_wr && (io_addr == CTL_ADDR);
    assign mask_wr = io_wr && (io_addr == MASK_ADDR);
    assign err_vec = {~iochk_n_i, par_err_i};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        nmi_src_latch u_src (
            .clk       (clk),
            .rst_n     (rst_n),
            .err_i     (err_vec[s]),
            .ctl_wr_i  (ctl_wr),
            .dis_bit_i (io_wdata[DIS_LSB+s]),
            .dis_o     (dis_vec[s]),
            .stat_o    (stat_vec[s])
        );
    end

    always_comb begin
        st_d = st_q;
        if (refresh_tick_i) begin
            st_d.refr = ~st_q.refr;
        end
        if (ctl_wr) begin
            st_d.spk  = io_wdata[1];
            st_d.gate = io_wdata[0];
        end
        if (mask_wr) begin
            st_d.mask = io_wdata[7];
            st_d.idx  = io_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mask: 1'b1, idx: '0, refr: 1'b0, spk: 1'b0, gate: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        io_rdata = '0;
        if (io_addr == CTL_ADDR) begin
            io_rdata = {stat_vec[0], stat_vec[1], cnt2_out_i, st_q.refr,
                        dis_vec[1], dis_vec[0], st_q.spk, st_q.gate};
        end else if (io_addr == MASK_ADDR) begin
            io_rdata = {st_q.mask, st_q.idx};
        end
    end

    assign gated_req = (|stat_vec) && !st_q.mask;

    nmi_pulse u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (gated_req),
        .pulse_o (nmi_o)
    );

    assign cnt2_gate_o = st_q.gate;
    assign spkr_data_o = st_q.spk;
    assign rtc_index_o = st_q.idx;

    // R12: no pulse while the mask has been set for two cycles
    assert_mask_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask && $past(st_q.mask)) |-> !nmi_o);
    // R10: a mask-port write reaches the index output
    assert_index_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (rtc_index_o == $past(io_wdata[6:0])));
    // R7: the refresh bit flips on each tick
    assert_refresh_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_tick_i |=> (st_q.refr != $past(st_q.refr)));
    // R9: the speaker and gate pins keep their value without a control write
    assert_misc_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> ($stable(spkr_data_o) && $stable(cnt2_gate_o)));
endmodule

// File: tb/nmi_ctrl_port_tb.sv
module nmi_ctrl_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_CTL  = 16'h0061;
    localparam logic [15:0] A_MASK = 16'h0070;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = A_CTL;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        par_err_i = 1'b0;
    logic        iochk_n_i = 1'b1;
    logic        refresh_tick_i = 1'b0;
    logic        cnt2_out_i = 1'b0;
    logic        nmi_o, cnt2_gate_o, spkr_data_o;
    logic [6:0]  rtc_index_o;

    int n_tests = 0;
    int n_fail  = 0;
    int nmi_seen = 0;
    bit done = 1'b0;

    // bench model
    bit m_par, m_chk, m_pdis, m_cdis, m_ref, m_spk, m_gate, m_mask, m_reqp, m_nmi;
    bit [6:0] m_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    nmi_ctrl_port dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .par_err_i(par_err_i),
        .iochk_n_i(iochk_n_i), .refresh_tick_i(refresh_tick_i),
        .cnt2_out_i(cnt2_out_i), .nmi_o(nmi_o), .cnt2_gate_o(cnt2_gate_o),
        .spkr_data_o(spkr_data_o), .rtc_index_o(rtc_index_o)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_par = 0; m_chk = 0; m_pdis = 1; m_cdis = 1; m_ref = 0;
        m_spk = 0; m_gate = 0; m_mask = 1; m_idx = '0; m_reqp = 0; m_nmi = 0;
    endtask

    task automatic check_outputs();
        if (io_addr == A_CTL) begin
            chk("R2", {7'd0, io_rdata[7]}, {7'd0, m_par});
            chk("R3", {7'd0, io_rdata[6]}, {7'd0, m_chk});
            chk("R8", {7'd0, io_rdata[5]}, {7'd0, cnt2_out_i});
            chk("R7", {7'd0, io_rdata[4]}, {7'd0, m_ref});
            chk("R5", {7'd0, io_rdata[3]}, {7'd0, m_cdis});
            chk("R4", {7'd0, io_rdata[2]}, {7'd0, m_pdis});
            chk("R9", {6'd0, io_rdata[1:0]}, {6'd0, m_spk, m_gate});
        end else if (io_addr == A_MASK) begin
            chk("R10", io_rdata, {m_mask, m_idx});
        end else begin
            chk("R13", io_rdata, 8'h00);
        end
        chk("R11", {7'd0, nmi_o}, {7'd0, m_nmi});
        chk("R9", {6'd0, spkr_data_o, cnt2_gate_o}, {6'd0, m_spk, m_gate});
        chk("R10", {1'b0, rtc_index_o}, {1'b0, m_idx});
        if (nmi_o) nmi_seen++;
    endtask

    // one clock: check current outputs, drive inputs, advance the model
    task automatic cycle(bit wr, logic [15:0] a, logic [7:0] wd,
                         bit pe, bit cn, bit tk, bit c2);
        bit w61, w70, req;
        bit n_par, n_chk;
        @(negedge clk);
        check_outputs();
        io_wr = wr; io_addr = a; io_wdata = wd;
        par_err_i = pe; iochk_n_i = cn; refresh_tick_i = tk; cnt2_out_i = c2;
        w61 = wr && (a == A_CTL);
        w70 = wr && (a == A_MASK);
        n_par = (w61 && wd[2]) ? 1'b0 : ((!m_pdis && pe) ? 1'b1 : m_par);
        n_chk = (w61 && wd[3]) ? 1'b0 : ((!m_cdis && !cn) ? 1'b1 : m_chk);
        req = (m_par || m_chk) && !m_mask;
        m_nmi = req && !m_reqp;
        m_reqp = req;
        m_par = n_par;
        m_chk = n_chk;
        if (w61) begin
            m_pdis = wd[2]; m_cdis = wd[3]; m_spk = wd[1]; m_gate = wd[0];
        end
        if (w70) begin
            m_mask = wd[7]; m_idx = wd[6:0];
        end
        if (tk) m_ref = ~m_ref;
        @(posedge clk);
    endtask

    task automatic idle(int n, logic [15:0] a);
        for (int i = 0; i < n; i++) cycle(0, a, 8'h00, 0, 1, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int cnt;
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        io_addr = A_CTL;
        #1 chk("R1", io_rdata, 8'h0C);
        cnt2_out_i = 1'b1;
        #1 chk("R1", io_rdata, 8'h2C);
        cnt2_out_i = 1'b0;
        io_addr = A_MASK;
        #1 chk("R1", io_rdata, 8'h80);
        chk("R1", {7'd0, nmi_o}, 8'h00);
        chk("R1", {1'b0, rtc_index_o}, 8'h00);
        @(posedge clk);

        // enable both sources, unmask, parity pulse for one cycle
        cycle(1, A_CTL, 8'h03, 0, 1, 0, 0);
        cycle(1, A_MASK, 8'h05, 0, 1, 0, 0);
        nmi_seen = 0;
        cycle(0, A_CTL, 8'h00, 1, 1, 0, 0);
        idle(6, A_CTL);
        chk("R2", {7'd0, io_rdata[7]}, 8'h01);
        chk("R11", nmi_seen[7:0], 8'h01);

        // R6: upper data bits ignored, status kept
        cycle(1, A_CTL, 8'hF0, 0, 1, 0, 0);
        idle(2, A_CTL);
        chk("R6", io_rdata & 8'hF0, 8'h80);

        // R4: clear and disable parity; error held high has no effect
        cycle(1, A_CTL, 8'h04, 1, 1, 0, 0);
        for (int i = 0; i < 4; i++) cycle(0, A_CTL, 8'h00, 1, 1, 0, 0);
        chk("R4", io_rdata & 8'h84, 8'h04);

        // R12: mask held, I/O check latches without a pulse
        cycle(1, A_MASK, 8'h80, 0, 1, 0, 0);
        idle(2, A_CTL);
        nmi_seen = 0;
        cycle(0, A_CTL, 8'h00, 0, 0, 0, 0);
        idle(5, A_CTL);
        chk("R12", nmi_seen[7:0], 8'h00);
        chk("R3", {7'd0, io_rdata[6]}, 8'h01);
        cycle(1, A_MASK, 8'h11, 0, 1, 0, 0);
        idle(5, A_CTL);
        chk("R12", nmi_seen[7:0], 8'h01);

        // R5: clear I/O check
        cycle(1, A_CTL, 8'h08, 0, 0, 0, 0);
        idle(3, A_CTL);
        chk("R5", io_rdata & 8'h48, 8'h08);

        // R7: two refresh ticks
        cycle(0, A_CTL, 8'h00, 0, 1, 1, 0);
        cycle(0, A_CTL, 8'h00, 0, 1, 1, 0);
        idle(1, A_CTL);

        // R13: other address
        cycle(1, 16'h0062, 8'hFF, 0, 1, 0, 1);
        idle(2, 16'h0062);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            cnt = $urandom_range(0, 9);
            a = (cnt < 5) ? A_CTL : ((cnt < 8) ? A_MASK : 16'($urandom_range(0, 255)));
            cycle($urandom_range(0, 4) == 0, a, 8'($urandom),
                  $urandom_range(0, 9) == 0, $urandom_range(0, 9) != 0,
                  $urandom_range(0, 3) == 0, 1'($urandom));
        end
        @(negedge clk);
        check_outputs();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule